// File: doc/BRIEF.md
# Synthesizer Divider Command Register File

This block holds the divider settings of a frequency synthesizer behind a small synchronous register interface. It keeps two copies of the settings. The shadow copy is what software reads and writes. The active copy drives the divider outputs: a 10-bit feedback divider, a 3-bit post-divider A, a 1-bit post-divider B and a 1-bit pre-divider. The register interface takes the place of a serial-bus slave. A read strobe returns the addressed register on `rdata` one clock later, and a write strobe stores `wdata` at the addressed register.

A write-only command location moves data between the two copies. It can also step the active feedback divider by one in either direction. Stepping does not touch the shadow copy, so a frequency can be nudged repeatedly without a reload. The PLL lock indication is synchronized and shown as a read-only status bit. No command is checked for validity or range.

Top module: `synth_divider_regs`

## Requirements
- R1: Address 0x00 reads and writes bits 7..0 of the shadow feedback divider; a read strobe in one cycle presents the value on `rdata` after the next clock edge, and `rdata` holds while no read strobe is given.
- R2: Address 0x01 holds, from bit 7 down to bit 1: feedback divider bits 9 and 8, post-divider A bits 2..0, post-divider B, and the pre-divider.
- R3: Bit 0 of address 0x01 reads the lock input after a two-flop synchronizer, and writes to that bit have no effect.
- R4: Writes to address 0x00 or 0x01 never change the active divider outputs.
- R5: Writing 0x01 to address 0xF0 (load) copies the whole shadow copy into the active outputs in the next cycle.
- R6: Writing 0x02 to address 0xF0 (get) copies the active settings into the shadow copy, so that later reads return the live configuration.
- R7: Writing 0x03 to address 0xF0 (step up) adds one to the active feedback divider, wrapping from 1023 to 0.
- R8: Writing 0x04 to address 0xF0 (step down) subtracts one from the active feedback divider, wrapping from 0 to 1023.
- R9: Step up and step down leave the shadow copy and the active post- and pre-divider outputs unchanged.
- R10: Any other value written to address 0xF0 changes neither the shadow nor the active copy.
- R11: A read of 0xF0 or of any unmapped address returns 0x00, and writes to unmapped addresses are ignored.
- R12: A synchronous active-high reset clears every shadow and active field and `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| lock_in | input | 1 | Asynchronous PLL lock indication |
| m_active | output | 10 | Active feedback divider |
| na_active | output | 3 | Active post-divider A |
| nb_active | output | 1 | Active post-divider B |
| p_active | output | 1 | Active pre-divider |

## Verification
The bench goes after the wrap points of the step commands: 1023 stepping up to 0 and 0 stepping down to 1023. A design with the wrong width or saturating arithmetic would stop or spill into neighbouring fields there. It writes shadow registers without a load and then checks that the outputs stay put. A design that drove its outputs straight from the shadow copy would move the frequency early. It reads back after stepping and after a get, which exposes a design that writes the shadow copy on a step or that fails to capture the live values. It also sends unknown command codes and unmapped accesses, writes the lock bit, and times the lock edge against reads, so that a design with a missing synchronizer stage or a writable lock bit shows up.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    parameter int unsigned ADDR_W = 8;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned M_W    = 10;
    parameter int unsigned NA_W   = 3;

    localparam int unsigned M_HI_W = M_W - DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_M_LO = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_M_HI = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_CMD  = 8'hF0;

    typedef enum logic [DATA_W-1:0] {
        CMD_LOAD = 8'h01,
        CMD_GET  = 8'h02,
        CMD_INC  = 8'h03,
        CMD_DEC  = 8'h04
    } cmd_e;

    typedef struct packed {
        logic [M_W-1:0]  m;
        logic [NA_W-1:0] na;
        logic            nb;
        logic            p;
    } div_cfg_t;
endpackage

// File: rtl/synth_lock_sync.sv
module synth_lock_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/synth_reg_decode.sv
module synth_reg_decode
    import synth_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  div_cfg_t          shadow,
    input  logic              lock_bit,
    output logic              wr_m_lo,
    output logic              wr_m_hi,
    output logic              wr_cmd,
    output logic [DATA_W-1:0] rd_val
);
    always_comb begin
        wr_m_lo = wr_en && (addr == ADDR_M_LO);
        wr_m_hi = wr_en && (addr == ADDR_M_HI);
        wr_cmd  = wr_en && (addr == ADDR_CMD);
    end

    always_comb begin
        case (addr)
            ADDR_M_LO: rd_val = shadow.m[DATA_W-1:0];
            ADDR_M_HI: rd_val = {shadow.m[M_W-1:DATA_W], shadow.na,
                                 shadow.nb, shadow.p, lock_bit};
            default:   rd_val = '0;
        endcase
    end
endmodule

// File: rtl/synth_div_core.sv
module synth_div_core
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_m_lo,
    input  logic              wr_m_hi,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_val,
    output div_cfg_t          shadow,
    output div_cfg_t          active,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        div_cfg_t          shadow;
        div_cfg_t          active;
        logic [DATA_W-1:0] rdata;
    } core_state_t;

    core_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;

        if (wr_m_lo) begin
            state_d.shadow.m[DATA_W-1:0] = wdata;
        end

        if (wr_m_hi) begin
            {state_d.shadow.m[M_W-1:DATA_W], state_d.shadow.na,
             state_d.shadow.nb, state_d.shadow.p} = wdata[DATA_W-1:1];
        end

        if (wr_cmd) begin
            case (cmd_e'(wdata))
                CMD_LOAD: state_d.active   = state_q.shadow;
                CMD_GET:  state_d.shadow   = state_q.active;
                CMD_INC:  state_d.active.m = state_q.active.m + 1'b1;
                CMD_DEC:  state_d.active.m = state_q.active.m - 1'b1;
                default:  ;
            endcase
        end

        if (rd_en) begin
            state_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign shadow = state_q.shadow;
    assign active = state_q.active;
    assign rdata  = state_q.rdata;
endmodule

// File: rtl/synth_divider_regs.sv
module synth_divider_regs
    import synth_cfg_pkg::*;
#(
    parameter int unsigned LOCK_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              lock_in,
    output logic [M_W-1:0]    m_active,
    output logic [NA_W-1:0]   na_active,
    output logic              nb_active,
    output logic              p_active
);
    logic              lock_bit;
    logic              wr_m_lo;
    logic              wr_m_hi;
    logic              wr_cmd;
    logic [DATA_W-1:0] rd_val;
    div_cfg_t          shadow_cfg;
    div_cfg_t          active_cfg;

    synth_lock_sync #(.STAGES(LOCK_STAGES)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .async_in (lock_in),
        .sync_out (lock_bit)
    );

    synth_reg_decode u_dec (
        .addr     (addr),
        .wr_en    (wr_en),
        .shadow   (shadow_cfg),
        .lock_bit (lock_bit),
        .wr_m_lo  (wr_m_lo),
        .wr_m_hi  (wr_m_hi),
        .wr_cmd   (wr_cmd),
        .rd_val   (rd_val)
    );

    synth_div_core u_core (
        .clk     (clk),
        .rst     (rst),
        .wr_m_lo (wr_m_lo),
        .wr_m_hi (wr_m_hi),
        .wr_cmd  (wr_cmd),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .rd_val  (rd_val),
        .shadow  (shadow_cfg),
        .active  (active_cfg),
        .rdata   (rdata)
    );

    assign m_active  = active_cfg.m;
    assign na_active = active_cfg.na;
    assign nb_active = active_cfg.nb;
    assign p_active  = active_cfg.p;
endmodule

// File: rtl/synth_divider_regs_chk.sv
module synth_divider_regs_chk
    import synth_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic [M_W-1:0]    m_active,
    input logic [NA_W-1:0]   na_active,
    input logic              nb_active,
    input logic              p_active,
    input div_cfg_t          shadow_cfg
);
    logic cmd_wr;
    logic step_cmd;
    logic bad_cmd;

    assign cmd_wr   = wr_en && (addr == ADDR_CMD);
    assign step_cmd = cmd_wr && ((wdata == CMD_INC) || (wdata == CMD_DEC));
    assign bad_cmd  = cmd_wr && ((wdata == 8'h00) || (wdata > CMD_DEC));

    a_r1_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    a_r4_plain_write_keeps_active: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == ADDR_M_LO || addr == ADDR_M_HI))
        |=> $stable({m_active, na_active, nb_active, p_active}));

    a_r5_load_copies_shadow: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata == CMD_LOAD)
        |=> ({m_active, na_active, nb_active, p_active} == $past(shadow_cfg)));

    a_r7_inc_adds_one: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata == CMD_INC) |=> (m_active == M_W'($past(m_active) + 1'b1)));

    a_r8_dec_subtracts_one: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata == CMD_DEC) |=> (m_active == M_W'($past(m_active) - 1'b1)));

    a_r9_step_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        step_cmd |=> ($stable(shadow_cfg) && $stable({na_active, nb_active, p_active})));

    a_r10_bad_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
        bad_cmd |=> ($stable(shadow_cfg) &&
                     $stable({m_active, na_active, nb_active, p_active})));

    a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != ADDR_M_LO && addr != ADDR_M_HI) |=> (rdata == '0));

    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (m_active == '0 && na_active == '0 && !nb_active && !p_active &&
                 shadow_cfg == '0 && rdata == '0));
endmodule

bind synth_divider_regs synth_divider_regs_chk u_chk (.*);

// File: tb/sim_synth_divider_regs.sv
module sim_synth_divider_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       lock_in = 1'b0;
    logic [9:0] m_active;
    logic [2:0] na_active;
    logic       nb_active;
    logic       p_active;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model of the requirements
    logic [9:0] sm, am;
    logic [2:0] sna, ana;
    logic       snb, sp, anb, ap;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    synth_divider_regs u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .lock_in(lock_in), .m_active(m_active),
        .na_active(na_active), .nb_active(nb_active), .p_active(p_active)
    );

    task automatic model_clear();
        sm = '0; sna = '0; snb = 0; sp = 0;
        am = '0; ana = '0; anb = 0; ap = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        if (a == 8'h00) sm[7:0] = d;
        else if (a == 8'h01) {sm[9:8], sna, snb, sp} = d[7:1];
        else if (a == 8'hF0) begin
            case (d)
                8'h01: begin am = sm; ana = sna; anb = snb; ap = sp; end
                8'h02: begin sm = am; sna = ana; snb = anb; sp = ap; end
                8'h03: am = am + 1'b1;
                8'h04: am = am - 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic lk, input string tag);
        logic [7:0] e;
        @(negedge clk);
        addr = a; wr_en = 1'b0; rd_en = 1'b1;
        if (a == 8'h00)      e = sm[7:0];
        else if (a == 8'h01) e = {sm[9:8], sna, snb, sp, lk};
        else                 e = 8'h00;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic check_active(input string tag);
        n_tests++;
        if ({m_active, na_active, nb_active, p_active} !== {am, ana, anb, ap}) begin
            n_fail++;
            $display("FAIL %s: active m=%h na=%h nb=%b p=%b expected m=%h na=%h nb=%b p=%b",
                     tag, m_active, na_active, nb_active, p_active, am, ana, anb, ap);
        end
    endtask

    // monitor: pops one expected item for every read strobe taken at an edge
    always @(posedge clk) rd_seen <= rd_en && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
            end
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_active("R12 reset state");
        rd(8'h00, 1'b0, "R12 reset shadow lo");
        rd(8'h01, 1'b0, "R12 reset shadow hi");

        wr(8'h00, 8'hA5);
        wr(8'h01, 8'hBF);                // lock bit written as 1
        idle();
        check_active("R4 shadow write leaves active");
        rd(8'h00, 1'b0, "R1 shadow lo readback");
        rd(8'h01, 1'b0, "R2 R3 shadow hi layout, lock read-only");
        idle();
        n_tests++;
        if (rdata !== 8'hBE) begin
            n_fail++;
            $display("FAIL R1 rdata hold: rdata=%h expected be", rdata);
        end

        wr(8'hF0, 8'h01); idle();
        check_active("R5 load");
        wr(8'hF0, 8'h03); idle();
        check_active("R7 step up");
        rd(8'h00, 1'b0, "R9 step keeps shadow");
        wr(8'hF0, 8'h04);
        wr(8'hF0, 8'h04); idle();
        check_active("R8 R9 step down twice");

        wr(8'hF0, 8'h00);
        wr(8'hF0, 8'h05);
        wr(8'hF0, 8'hFF); idle();
        check_active("R10 unknown commands");
        rd(8'h00, 1'b0, "R10 unknown commands keep shadow");

        wr(8'hF0, 8'h02);
        rd(8'h00, 1'b0, "R6 get lo");
        rd(8'h01, 1'b0, "R6 get hi");

        wr(8'h00, 8'hFF);
        wr(8'h01, 8'hC0);
        wr(8'hF0, 8'h01); idle();
        check_active("R5 load top value");
        wr(8'hF0, 8'h03); idle();
        check_active("R7 wrap 1023 to 0");
        wr(8'hF0, 8'h04); idle();
        check_active("R8 wrap 0 to 1023");

        wr(8'h02, 8'h55);
        wr(8'h7F, 8'h01);
        rd(8'h02, 1'b0, "R11 unmapped read");
        rd(8'hF0, 1'b0, "R11 command read");
        rd(8'h00, 1'b0, "R11 unmapped write ignored lo");
        rd(8'h01, 1'b0, "R11 unmapped write ignored hi");
        idle();
        check_active("R11 unmapped write keeps active");

        @(negedge clk) lock_in = 1'b1;
        rd(8'h01, 1'b0, "R3 lock not yet through synchronizer");
        rd(8'h01, 1'b1, "R3 lock after two stages");
        idle();

        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        lock_in = 1'b0;
        model_clear();
        check_active("R12 reset mid-run");
        rd(8'h00, 1'b0, "R12 reset clears shadow");
        idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule